// File: doc/BRIEF.md
# Indexed Sound Register Bank

This block is the host-facing register store of a three-channel sound generator. The host drives three strobes. An index strobe latches a register number, and that number stays selected. Any number of later data writes and data reads then reach that same register until a new number is latched. All sixteen registers can be read back. From their contents the block presents decoded fields to the tone, noise, amplitude and envelope logic, which sit outside this block.

Two 8-bit general-purpose ports share the bank. Each port has a stored output byte, and its direction comes from one of the two top bits of the mixer register. When a port is set to input, a read of its register returns the external pins rather than the stored byte. All state is cleared by a synchronous active-high reset, and the reset leaves both ports as inputs.

Top module: `snd_regbank`

## Requirements
- R1: After reset, every register reads 0, `dout` is 0, both port enables are 0, and both `tone_en` and `noise_en` are 3'b111.
- R2: An `addr_we` strobe latches `din[3:0]` as the selected index and ignores `din[7:4]`. The index holds without change until the next `addr_we`, so repeated data writes without a new index all land in the same register.
- R3: A `data_re` strobe loads the selected register's value into `dout` at that clock edge. While `data_re` is low, `dout` keeps its value.
- R4: Registers 1, 3 and 5 keep only the low 4 bits of a write, and their bits 7:4 read back as 0. `tone_per[c]` equals `{reg[2c+1][3:0], reg[2c]}` for channel c = 0..2.
- R5: `env_per` equals `{reg12, reg11}`, and `env_shape` equals `reg13[3:0]`.
- R6: The enables in register 7 are active-low. `tone_en[c]` = NOT `reg7[c]` and `noise_en[c]` = NOT `reg7[3+c]`. `noise_per` equals `reg6[4:0]`.
- R7: For channel c, `amp_lvl[c]` equals `reg(8+c)[3:0]` and `amp_env[c]` equals `reg(8+c)[4]`.
- R8: `pa_oe` follows `reg7[6]` and `pb_oe` follows `reg7[7]`, with 1 meaning output. `pa_out` and `pb_out` always drive the stored `reg14` and `reg15`.
- R9: A read of register 14 or 15 returns the stored byte when its port is an output. When the port is an input, the read returns the pin value sampled at the previous clock edge.
- R10: When strobes collide in one cycle, a data write goes to the index that was latched before that cycle, and a data read returns the register's content from before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_we | input | 1 | Latch register index from `din` |
| data_we | input | 1 | Write `din` to selected register |
| data_re | input | 1 | Load selected register into `dout` |
| din | input | 8 | Host data / index byte |
| dout | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pins, input side |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pins, input side |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 1 | Port B output enable |
| tone_per | output | 3x12 | Per-channel tone period |
| noise_per | output | 5 | Noise period |
| tone_en | output | 3 | Per-channel tone enable (active-high) |
| noise_en | output | 3 | Per-channel noise enable (active-high) |
| amp_lvl | output | 3x4 | Per-channel fixed amplitude |
| amp_env | output | 3 | Per-channel envelope-amplitude select |
| env_per | output | 16 | Envelope period |
| env_shape | output | 4 | Envelope shape code |

## Verification
The bench builds the block with the package defaults: 8-bit data, sixteen registers and three channels. These values put the full 4-bit index range within reach, including address bytes whose upper nibble must be dropped. They also cover all three masked tone high registers and both port direction bits in the mixer byte. Random index bytes, data bytes and pin changes mix with directed collisions and input/output flips of both ports.

// File: rtl/snd_regbank_pkg.sv
package snd_regbank_pkg;
  localparam int DW        = 8;
  localparam int NREG      = 16;
  localparam int IDX_W     = $clog2(NREG);
  localparam int NCH       = 3;
  localparam int NPORT     = 2;
  localparam int TONE_HI_W = 4;
  localparam int TONE_W    = DW + TONE_HI_W;
  localparam int AMP_W     = 4;
  localparam int NOISE_W   = 5;
  localparam int ENV_W     = 2 * DW;
  localparam int SHAPE_W   = 4;

  localparam int R_NOISE   = 6;
  localparam int R_MIX     = 7;
  localparam int R_AMP0    = 8;
  localparam int R_ENV_LO  = 11;
  localparam int R_ENV_HI  = 12;
  localparam int R_SHAPE   = 13;
  localparam int R_PORT0   = 14;

  localparam int MIX_NOISE0 = 3;
  localparam int MIX_DIR0   = 6;

  // bits kept on write: tone high registers hold only TONE_HI_W bits
  function automatic logic [DW-1:0] keep_mask(int idx);
    if (idx < 2 * NCH && (idx % 2) == 1)
      return {{(DW - TONE_HI_W){1'b0}}, {TONE_HI_W{1'b1}}};
    return '1;
  endfunction
endpackage

// File: rtl/snd_idx_latch.sv
module snd_idx_latch #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] nxt,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (load) idx <= nxt;
  end
endmodule

// File: rtl/snd_reg_file.sv
module snd_reg_file
  import snd_regbank_pkg::*;
#(
  parameter int N   = NREG,
  parameter int W   = DW,
  parameter int IW  = IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IW-1:0]       widx,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] regs
);
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst)
        regs[i] <= '0;
      else if (we && widx == IW'(i))
        regs[i] <= wdata & keep_mask(i);
    end
  end
endmodule

// File: rtl/snd_gpio_port.sv
module snd_gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_out,
  input  logic [W-1:0] stored,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic         pin_oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_in;
  end

  assign pin_out = stored;
  assign pin_oe  = dir_out;
  assign rd_val  = dir_out ? stored : pin_q;
endmodule

// File: rtl/snd_regbank.sv
module snd_regbank
  import snd_regbank_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       addr_we,
  input  logic                       data_we,
  input  logic                       data_re,
  input  logic [DW-1:0]              din,
  output logic [DW-1:0]              dout,
  input  logic [DW-1:0]              pa_in,
  output logic [DW-1:0]              pa_out,
  output logic                       pa_oe,
  input  logic [DW-1:0]              pb_in,
  output logic [DW-1:0]              pb_out,
  output logic                       pb_oe,
  output logic [NCH-1:0][TONE_W-1:0] tone_per,
  output logic [NOISE_W-1:0]         noise_per,
  output logic [NCH-1:0]             tone_en,
  output logic [NCH-1:0]             noise_en,
  output logic [NCH-1:0][AMP_W-1:0]  amp_lvl,
  output logic [NCH-1:0]             amp_env,
  output logic [ENV_W-1:0]           env_per,
  output logic [SHAPE_W-1:0]         env_shape
);
  logic [IDX_W-1:0]          sel_idx;
  logic [NREG-1:0][DW-1:0]   regs;
  logic [NPORT-1:0][DW-1:0]  p_in, p_out, p_rd;
  logic [NPORT-1:0]          p_oe;
  logic [DW-1:0]             rd_mux;

  snd_idx_latch #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst(rst), .load(addr_we),
    .nxt(din[IDX_W-1:0]), .idx(sel_idx)
  );

  snd_reg_file #(.N(NREG), .W(DW), .IW(IDX_W)) u_rf (
    .clk(clk), .rst(rst), .we(data_we), .widx(sel_idx),
    .wdata(din), .regs(regs)
  );

  assign p_in[0] = pa_in;
  assign p_in[1] = pb_in;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    snd_gpio_port #(.W(DW)) u_port (
      .clk(clk), .rst(rst),
      .dir_out(regs[R_MIX][MIX_DIR0+p]),
      .stored(regs[R_PORT0+p]),
      .pin_in(p_in[p]),
      .pin_out(p_out[p]),
      .pin_oe(p_oe[p]),
      .rd_val(p_rd[p])
    );
  end

  assign pa_out = p_out[0];
  assign pb_out = p_out[1];
  assign pa_oe  = p_oe[0];
  assign pb_oe  = p_oe[1];

  always_comb begin
    rd_mux = regs[sel_idx];
    for (int p = 0; p < NPORT; p++)
      if (sel_idx == IDX_W'(R_PORT0 + p)) rd_mux = p_rd[p];
  end

  always_ff @(posedge clk) begin
    if (rst)          dout <= '0;
    else if (data_re) dout <= rd_mux;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign tone_per[c] = {regs[2*c+1][TONE_HI_W-1:0], regs[2*c]};
    assign amp_lvl[c]  = regs[R_AMP0+c][AMP_W-1:0];
    assign amp_env[c]  = regs[R_AMP0+c][AMP_W];
    assign tone_en[c]  = ~regs[R_MIX][c];
    assign noise_en[c] = ~regs[R_MIX][MIX_NOISE0+c];
  end

  assign noise_per = regs[R_NOISE][NOISE_W-1:0];
  assign env_per   = {regs[R_ENV_HI], regs[R_ENV_LO]};
  assign env_shape = regs[R_SHAPE][SHAPE_W-1:0];

  logic unused_bits;
  assign unused_bits = ^{regs[1][DW-1:TONE_HI_W], regs[3][DW-1:TONE_HI_W],
                         regs[5][DW-1:TONE_HI_W], regs[R_NOISE][DW-1:NOISE_W],
                         regs[R_AMP0][DW-1:AMP_W+1], regs[R_AMP0+1][DW-1:AMP_W+1],
                         regs[R_AMP0+2][DW-1:AMP_W+1], regs[R_SHAPE][DW-1:SHAPE_W]};
endmodule

// File: rtl/snd_regbank_chk.sv
module snd_regbank_chk
  import snd_regbank_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             addr_we,
  input logic             data_we,
  input logic             data_re,
  input logic [DW-1:0]    din,
  input logic [DW-1:0]    dout,
  input logic [IDX_W-1:0] sel,
  input logic             pa_oe,
  input logic             pb_oe,
  input logic [NCH-1:0]   tone_en
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d === 1'b1)
      a_r1_reset_clear: assert (dout == '0 && !pa_oe && !pb_oe)
        else $error("reset state not clear");
  end

  a_r2_index_holds: assert property (@(posedge clk) disable iff (rst)
    !addr_we |=> $stable(sel));

  a_r3_dout_holds: assert property (@(posedge clk) disable iff (rst)
    !data_re |=> $stable(dout));

  a_r4_hi_nibble_zero: assert property (@(posedge clk) disable iff (rst)
    (data_re && sel < IDX_W'(2*NCH) && sel[0]) |=> dout[DW-1:TONE_HI_W] == '0);

  a_r6_mixer_low_active: assert property (@(posedge clk) disable iff (rst)
    (data_we && sel == IDX_W'(R_MIX)) |=> tone_en == ~$past(din[NCH-1:0]));

  a_r8_dir_follows: assert property (@(posedge clk) disable iff (rst)
    (data_we && sel == IDX_W'(R_MIX)) |=>
      (pa_oe == $past(din[MIX_DIR0]) && pb_oe == $past(din[MIX_DIR0+1])));
endmodule

bind snd_regbank snd_regbank_chk u_chk (
  .clk(clk), .rst(rst), .addr_we(addr_we), .data_we(data_we),
  .data_re(data_re), .din(din), .dout(dout), .sel(sel_idx),
  .pa_oe(pa_oe), .pb_oe(pb_oe), .tone_en(tone_en)
);

// File: tb/sim_snd_regbank.sv
module sim_snd_regbank;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_we = 0, data_we = 0, data_re = 0;
  logic [7:0] din = 0, pa_in = 0, pb_in = 0;
  logic [7:0] dout, pa_out, pb_out;
  logic pa_oe, pb_oe;
  logic [2:0][11:0] tone_per;
  logic [4:0] noise_per;
  logic [2:0] tone_en, noise_en, amp_env;
  logic [2:0][3:0] amp_lvl;
  logic [15:0] env_per;
  logic [3:0] env_shape;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] mem [16];
  logic [3:0] midx;
  logic [7:0] pins_a, pins_b;

  always #(CLK_P/2) clk = ~clk;

  snd_regbank u0 (
    .clk(clk), .rst(rst), .addr_we(addr_we), .data_we(data_we),
    .data_re(data_re), .din(din), .dout(dout),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .tone_per(tone_per), .noise_per(noise_per), .tone_en(tone_en),
    .noise_en(noise_en), .amp_lvl(amp_lvl), .amp_env(amp_env),
    .env_per(env_per), .env_shape(env_shape)
  );

  function automatic logic [7:0] wmask(int i);
    return (i == 1 || i == 3 || i == 5) ? 8'h0F : 8'hFF;
  endfunction

  function automatic logic [7:0] exp_read(int i);
    if (i == 14 && !mem[7][6]) return pins_a;
    if (i == 15 && !mem[7][7]) return pins_b;
    return mem[i];
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_fields();
    for (int c = 0; c < 3; c++) begin
      chk(tone_per[c] == {mem[2*c+1][3:0], mem[2*c]}, "R4 tone_per",
          32'(tone_per[c]), 32'({mem[2*c+1][3:0], mem[2*c]}));
      chk(amp_lvl[c] == mem[8+c][3:0] && amp_env[c] == mem[8+c][4], "R7 amp",
          32'({amp_env[c], amp_lvl[c]}), 32'(mem[8+c][4:0]));
      chk(tone_en[c] == ~mem[7][c] && noise_en[c] == ~mem[7][3+c], "R6 mixer",
          32'({noise_en[c], tone_en[c]}), 32'({~mem[7][3+c], ~mem[7][c]}));
    end
    chk(noise_per == mem[6][4:0], "R6 noise_per", 32'(noise_per), 32'(mem[6][4:0]));
    chk(env_per == {mem[12], mem[11]} && env_shape == mem[13][3:0], "R5 envelope",
        {12'h0, env_shape, env_per}, {12'h0, mem[13][3:0], mem[12], mem[11]});
    chk(pa_oe == mem[7][6] && pb_oe == mem[7][7] && pa_out == mem[14] && pb_out == mem[15],
        "R8 ports", {14'h0, pb_oe, pa_oe, pb_out, pa_out},
        {14'h0, mem[7][7], mem[7][6], mem[15], mem[14]});
  endtask

  // one clock with the given strobes; returns at the next falling edge
  task automatic step(bit aw, bit dw, bit dr, logic [7:0] d);
    logic [7:0] exp_rd;
    logic [7:0] old_dout;
    int ri;
    ri = int'(midx);
    exp_rd = exp_read(ri);
    old_dout = dout;
    addr_we = aw; data_we = dw; data_re = dr; din = d;
    @(negedge clk);
    addr_we = 0; data_we = 0; data_re = 0;
    if (dw) mem[ri] = d & wmask(ri);
    if (aw) midx = d[3:0];
    if (dr) begin
      if (ri == 14 || ri == 15)
        chk(dout == exp_rd, "R9 port read", 32'(dout), 32'(exp_rd));
      else if (ri == 1 || ri == 3 || ri == 5)
        chk(dout == exp_rd, "R4 masked read", 32'(dout), 32'(exp_rd));
      else
        chk(dout == exp_rd, "R3 read", 32'(dout), 32'(exp_rd));
    end else
      chk(dout == old_dout, "R3 hold", 32'(dout), 32'(old_dout));
    check_fields();
  endtask

  task automatic set_pins(logic [7:0] a, logic [7:0] b);
    pa_in = a; pb_in = b;
    @(negedge clk);
    pins_a = a; pins_b = b;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    midx = 0; pins_a = 0; pins_b = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(dout == 0 && !pa_oe && !pb_oe, "R1 reset outputs",
        {22'h0, pb_oe, pa_oe, dout}, 32'h0);
    chk(tone_en == 3'b111 && noise_en == 3'b111, "R1 reset enables",
        32'({noise_en, tone_en}), 32'h3F);
    for (int i = 0; i < 16; i++) begin
      step(1, 0, 0, 8'(i));
      step(0, 0, 1, 8'h00);
      chk(dout == 0, "R1 reset register", 32'(dout), 32'h0);
    end
    // R2 upper nibble of index ignored; repeated writes to one register
    step(1, 0, 0, 8'hF3);
    step(0, 1, 0, 8'hAB);
    step(0, 0, 1, 8'h00);
    chk(dout == 8'h0B, "R2 R4 index F3 -> reg3", 32'(dout), 32'h0B);
    step(1, 0, 0, 8'h9B);
    step(0, 1, 0, 8'h11);
    step(0, 1, 0, 8'h22);
    step(0, 1, 0, 8'hC7);
    step(0, 0, 1, 8'h00);
    chk(dout == 8'hC7, "R2 sticky index", 32'(dout), 32'hC7);
    // R9 port A input then output
    step(1, 0, 0, 8'h07);
    step(0, 1, 0, 8'h00);
    set_pins(8'h5A, 8'hE1);
    step(1, 0, 0, 8'h0E);
    step(0, 1, 0, 8'h33);
    step(0, 0, 1, 8'h00);
    chk(dout == 8'h5A, "R9 input mode A", 32'(dout), 32'h5A);
    step(1, 0, 0, 8'h07);
    step(0, 1, 0, 8'h40);
    step(1, 0, 0, 8'h0E);
    step(0, 0, 1, 8'h00);
    chk(dout == 8'h33, "R9 output mode A", 32'(dout), 32'h33);
    step(1, 0, 0, 8'h0F);
    step(0, 1, 0, 8'h77);
    step(0, 0, 1, 8'h00);
    chk(dout == 8'hE1, "R9 input mode B", 32'(dout), 32'hE1);
    // R10 collisions
    step(1, 0, 0, 8'h02);
    step(1, 1, 0, 8'h0D);
    chk(midx == 4'hD, "R10 index moved", 32'(midx), 32'hD);
    step(1, 0, 0, 8'h02);
    step(0, 0, 1, 8'h00);
    chk(dout == 8'h0D, "R10 write used old index", 32'(dout), 32'h0D);
    step(0, 1, 1, 8'h99);
    chk(dout == 8'h0D, "R10 read before write", 32'(dout), 32'h0D);
    step(0, 0, 1, 8'h00);
    chk(dout == 8'h99, "R10 write landed", 32'(dout), 32'h99);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom_range(0, 9));
      d = 8'($urandom);
      case (op)
        0, 1:    step(1, 0, 0, d);
        2, 3, 4: step(0, 1, 0, d);
        5, 6, 7: step(0, 0, 1, d);
        8:       set_pins(d, 8'($urandom));
        default: step(1'($urandom), 1'($urandom), 1'($urandom), d);
      endcase
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule